// File: doc/BRIEF.md
# Serial Memory Command Controller

This block sits behind an SPI slave front end and turns the byte stream of one chip-select period into operations on a 512-byte register array. The front end hands it each received byte with a one-cycle strobe, asks for each byte it must shift out with a one-cycle request, and signals the end of the transaction with a chip-select-rise event. The first byte of every transaction is a command. Memory commands then take an address byte, and the 9-bit start address is completed by one bit carried inside the command byte. Data then streams in or out without limit, and the address pointer advances after every byte.

Writes to the array land in the same cycle the byte arrives, so there is never a busy state. A write-enable flag gates every write. It is set and cleared by dedicated commands, and the completion of any write operation clears it. An external protection unit watches the current address and the two block-protect bits, and returns a per-byte permission for array writes and a separate permission for status writes.

Top module: `smem_cmd_ctrl`

## Requirements
- R1: After reset the write-enable flag and both block-protect bits are 0, `addr_o` is 000h and `tx_byte` is 00h.
- R2: The first byte after reset or after a `cs_rise` is decoded as a command: 06h enable writes, 04h disable writes, 05h read status, 01h write status, 0000_A011b read memory, 0000_A010b write memory. No later byte of the same transaction is decoded as a command.
- R3: For read and write memory, the next byte supplies address bits 7..0 and bit 3 of the command supplies address bit 8. The 9-bit result appears on `addr_o` one cycle after the address byte.
- R4: In the write-data phase each received byte is stored at `addr_o` in the cycle it arrives, but only if the write-enable flag is 1 and `mem_wr_ok` is 1. The pointer advances by one for every data byte, stored or dropped.
- R5: The address pointer wraps from 1FFh to 000h in both read and write bursts.
- R6: In the read-data phase each `tx_req` yields `tx_vld` one cycle later with the byte at the pointer, and the pointer then advances. Received bytes are ignored in this phase.
- R7: The enable command sets the write-enable flag and the disable command clears it. The flag is bit 1 of the status byte.
- R8: During read status, every `tx_req` returns the status byte {0000b, bp[1:0], flag, 0b}, repeated for as long as requests continue.
- R9: Write status takes one byte. If the flag is 1 and `sr_wr_ok` is 1, bits 3..2 of that byte become the block-protect bits. All other bits of the byte are ignored, and the flag is cleared whether or not the write was allowed.
- R10: A `cs_rise` that ends a write-memory transaction clears the write-enable flag.
- R11: After an unrecognised command every further byte is ignored until `cs_rise`. Every `tx_req` outside a read-data or read-status phase returns 00h.
- R12: `cs_rise` ends any transaction in progress, and the next received byte is treated as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first already assembled |
| tx_req | input | 1 | One-cycle request for the next byte to shift out |
| cs_rise | input | 1 | One-cycle event: chip select went inactive |
| mem_wr_ok | input | 1 | Protection unit allows an array write at `addr_o` |
| sr_wr_ok | input | 1 | Protection unit allows a status write |
| tx_byte | output | 8 | Byte answering the last `tx_req` |
| tx_vld | output | 1 | `tx_byte` is fresh (one cycle after `tx_req`) |
| addr_o | output | 9 | Current address pointer |
| bp_o | output | 2 | Block-protect bits for the protection unit |

## Verification
The assertions assume that `rx_valid`, `tx_req` and `cs_rise` are single-cycle strobes that never coincide. They also assume that `mem_wr_ok` is settled against the `addr_o` value shown in the cycle a data byte arrives. The bench drives every strobe for exactly one cycle, separated by at least one idle cycle, and changes the permission inputs only between strobes. The scoreboard predicts array contents from a shadow copy that is updated only when a write should land. For that reason it reads back only locations it has written.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [2:0] {
        ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRD, ST_SWR, ST_SKIP
    } sess_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
    } op_t;

    typedef struct packed {
        logic [1:0] bp;
        logic       wel;
    } stat_t;

    function automatic op_t decode_op(input logic [DATA_W-1:0] b);
        op_t r;
        r = OP_NONE;
        if (b[7:4] == 4'h0) begin
            if (b[2:0] == 3'b011)      r = OP_READ;
            else if (b[2:0] == 3'b010) r = OP_WRITE;
            else if (b[3] == 1'b0) begin
                case (b[2:0])
                    3'b110:  r = OP_WREN;
                    3'b100:  r = OP_WRDI;
                    3'b101:  r = OP_RDSR;
                    3'b001:  r = OP_WRSR;
                    default: r = OP_NONE;
                endcase
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input stat_t s);
        return {4'b0000, s.bp, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/smem_array.sv
module smem_array
    import smem_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/smem_status.sv
module smem_status
    import smem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       sr_we,
    input  logic [1:0] sr_bp,
    output stat_t      stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            if (set_wel)      stat.wel <= 1'b1;
            else if (clr_wel) stat.wel <= 1'b0;
            if (sr_we)        stat.bp  <= sr_bp;
        end
    end
endmodule

// File: rtl/smem_seq.sv
module smem_seq
    import smem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              tx_req,
    input  logic              cs_rise,
    input  logic              wel,
    input  logic              mem_wr_ok,
    input  logic              sr_wr_ok,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_we,
    output logic              set_wel,
    output logic              clr_wel,
    output logic              sr_we,
    output logic [1:0]        sr_bp,
    output logic              rd_fire,
    output logic              sr_fire
);
    sess_t st;
    logic  hi_bit;
    logic  is_read;
    logic  wr_sess;
    logic  rx_go;
    op_t   op;

    assign rx_go = rx_valid && !cs_rise;
    assign op    = decode_op(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_OPC;
            addr    <= '0;
            hi_bit  <= 1'b0;
            is_read <= 1'b0;
            wr_sess <= 1'b0;
        end else if (cs_rise) begin
            st      <= ST_OPC;
            wr_sess <= 1'b0;
        end else begin
            if (rx_valid) begin
                case (st)
                    ST_OPC: begin
                        case (op)
                            OP_RDSR:  st <= ST_SRD;
                            OP_WRSR:  st <= ST_SWR;
                            OP_READ: begin
                                st      <= ST_ADDR;
                                is_read <= 1'b1;
                                hi_bit  <= rx_byte[3];
                            end
                            OP_WRITE: begin
                                st      <= ST_ADDR;
                                is_read <= 1'b0;
                                hi_bit  <= rx_byte[3];
                                wr_sess <= 1'b1;
                            end
                            default:  st <= ST_SKIP;
                        endcase
                    end
                    ST_ADDR: begin
                        addr <= {hi_bit, rx_byte};
                        st   <= is_read ? ST_RDATA : ST_WDATA;
                    end
                    ST_WDATA: addr <= addr + 1'b1;
                    ST_SWR:   st   <= ST_SKIP;
                    default: ;
                endcase
            end
            if (tx_req && st == ST_RDATA) addr <= addr + 1'b1;
        end
    end

    assign set_wel = rx_go && st == ST_OPC && op == OP_WREN;
    assign clr_wel = (rx_go && st == ST_OPC && op == OP_WRDI)
                   || (rx_go && st == ST_SWR)
                   || (cs_rise && wr_sess);
    assign sr_we   = rx_go && st == ST_SWR && wel && sr_wr_ok;
    assign sr_bp   = rx_byte[3:2];
    assign mem_we  = rx_go && st == ST_WDATA && wel && mem_wr_ok;
    assign rd_fire = tx_req && !cs_rise && st == ST_RDATA;
    assign sr_fire = tx_req && !cs_rise && st == ST_SRD;

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_go && st == ST_WDATA && addr == '1) |=> addr == '0);

    // R12
    cs_end_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> st == ST_OPC);
endmodule

// File: rtl/smem_cmd_ctrl.sv
module smem_cmd_ctrl
    import smem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    input  logic        cs_rise,
    input  logic        mem_wr_ok,
    input  logic        sr_wr_ok,
    output logic [7:0]  tx_byte,
    output logic        tx_vld,
    output logic [8:0]  addr_o,
    output logic [1:0]  bp_o
);
    stat_t             stat;
    logic              mem_we, set_wel, clr_wel, sr_we, rd_fire, sr_fire;
    logic [1:0]        sr_bp;
    logic [DATA_W-1:0] mem_rdata;

    smem_seq u_seq (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .cs_rise(cs_rise), .wel(stat.wel),
        .mem_wr_ok(mem_wr_ok), .sr_wr_ok(sr_wr_ok), .addr(addr_o),
        .mem_we(mem_we), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_we(sr_we), .sr_bp(sr_bp), .rd_fire(rd_fire), .sr_fire(sr_fire)
    );

    smem_status u_stat (
        .clk(clk), .rst(rst), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_we(sr_we), .sr_bp(sr_bp), .stat(stat)
    );

    smem_array u_mem (
        .clk(clk), .we(mem_we), .addr(addr_o), .wdata(rx_byte),
        .rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte <= '0;
            tx_vld  <= 1'b0;
        end else begin
            tx_vld <= tx_req && !cs_rise;
            if (rd_fire)      tx_byte <= mem_rdata;
            else if (sr_fire) tx_byte <= pack_stat(stat);
            else if (tx_req)  tx_byte <= '0;
        end
    end

    assign bp_o = stat.bp;

    // R6
    tx_src_chk: assert property (@(posedge clk) disable iff (rst)
        tx_vld |-> $past(tx_req));

    // R7
    wel_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.wel) |-> $past(rx_valid));

    // R4
    wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (stat.wel && mem_wr_ok && rx_valid));

    // R9
    bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rx_valid)) |-> $stable(bp_o));

    // R8
    stat_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_vld && $past(sr_fire)) |-> (tx_byte[7:4] == 4'h0 && tx_byte[0] == 1'b0));
endmodule

// File: tb/tb_smem_cmd_ctrl.sv
module tb_smem_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       cs_rise = 1'b0;
    logic       mem_wr_ok = 1'b1;
    logic       sr_wr_ok = 1'b1;
    logic [7:0] tx_byte;
    logic       tx_vld;
    logic [8:0] addr_o;
    logic [1:0] bp_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] shadow [512];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    smem_cmd_ctrl dut (.*);

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design answers
    always @(negedge clk) begin
        if (!rst && tx_vld) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected tx_vld", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(tx_byte), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic req(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
    endtask

    task automatic cs_end();
        @(negedge clk); cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
    endtask

    task automatic wren();
        send(8'h06); cs_end();
    endtask

    task automatic rdsr(input int n, input logic [7:0] e, input string tag);
        send(8'h05);
        for (int i = 0; i < n; i++) req(e, tag);
        cs_end();
    endtask

    task automatic wr_burst(input logic [8:0] a, input int n, input logic [7:0] d0, input bit lands);
        send({4'h0, a[8], 3'b010}); send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            send(d0 + 8'(i));
            if (lands) shadow[9'(a + 9'(i))] = d0 + 8'(i);
        end
        cs_end();
    endtask

    task automatic rd_burst(input logic [8:0] a, input int n, input string tag);
        send({4'h0, a[8], 3'b011}); send(a[7:0]);
        check("R3 address assembled", int'(addr_o), int'(a));
        for (int i = 0; i < n; i++) req(shadow[9'(a + 9'(i))], tag);
        cs_end();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 tx_byte", int'(tx_byte), 0);
        check("R1 bp", int'(bp_o), 0);
        check("R1 addr", int'(addr_o), 0);
        rdsr(1, 8'h00, "R1 status after reset");

        // R11: request before any command
        req(8'h00, "R11 idle request"); cs_end();

        wren();
        rdsr(2, 8'h02, "R7 R8 flag set, repeated");

        // R4 R5: burst across the top of the array
        wr_burst(9'h1FE, 4, 8'hA0, 1'b1);
        rdsr(1, 8'h00, "R10 flag cleared by write end");
        rd_burst(9'h1FE, 4, "R5 wrap readback");

        // R4: write without the flag is dropped
        wr_burst(9'h1FF, 1, 8'h55, 1'b0);
        rd_burst(9'h1FF, 1, "R4 no-flag write dropped");

        // R3: address bit 8 from command bit 3
        wren(); wr_burst(9'h105, 1, 8'h3C, 1'b1);
        wren(); wr_burst(9'h005, 1, 8'hC3, 1'b1);
        rd_burst(9'h105, 1, "R3 upper half");
        rd_burst(9'h005, 1, "R3 lower half");

        // R4: permission denied for one byte mid-burst
        wren(); wr_burst(9'h010, 3, 8'h70, 1'b1);
        wren();
        send(8'h02); send(8'h10);
        send(8'h11); shadow[9'h010] = 8'h11;
        mem_wr_ok = 1'b0; send(8'h22); mem_wr_ok = 1'b1;
        send(8'h33); shadow[9'h012] = 8'h33;
        cs_end();
        rd_burst(9'h010, 3, "R4 per-byte permission");

        // R6: received bytes ignored during read data
        send(8'h03); send(8'h10);
        req(shadow[9'h010], "R6 read stream");
        send(8'h06); send(8'hAA);
        req(shadow[9'h011], "R6 read stream");
        req(shadow[9'h012], "R6 read stream");
        cs_end();
        rdsr(1, 8'h00, "R2 byte in read phase not a command");
        rd_burst(9'h010, 1, "R6 ignored byte not stored");

        // R9: status write
        wren(); send(8'h01); send(8'hFF); cs_end();
        rdsr(2, 8'h0C, "R9 bp written, other bits fixed, flag cleared");
        check("R9 bp_o", int'(bp_o), 3);
        wren(); sr_wr_ok = 1'b0; send(8'h01); send(8'h00); cs_end(); sr_wr_ok = 1'b1;
        rdsr(1, 8'h0C, "R9 denied status write");
        wren(); send(8'h01); send(8'h04); cs_end();
        rdsr(1, 8'h04, "R9 bp=01");

        // R7: disable
        wren(); rdsr(1, 8'h06, "R7 set");
        send(8'h04); cs_end();
        rdsr(1, 8'h04, "R7 cleared by disable");

        // R2: one command per transaction
        send(8'h06); send(8'h05); req(8'h00, "R2 second command ignored"); cs_end();
        rdsr(1, 8'h06, "R2 first command taken");
        send(8'h04); send(8'h06); cs_end();
        rdsr(1, 8'h04, "R2 enable after disable ignored");

        // R11: unknown command
        wren();
        send(8'hFF); send(8'h04); req(8'h00, "R11 after unknown"); cs_end();
        rdsr(1, 8'h06, "R11 later byte not decoded");

        // R12: cs rise mid-write, next byte is a command
        send(8'h02); send(8'h20); send(8'h5A); shadow[9'h020] = 8'h5A; cs_end();
        send(8'h05); req(8'h04, "R12 new command after cs rise"); cs_end();
        rd_burst(9'h020, 1, "R12 byte before cs rise kept");

        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule